// File: doc/BRIEF.md
# Parallel Head-Unification Dispatcher

This block is the control unit of a head-unification engine built around a small pool of identical unification units. It accepts a stream of argument operations for one clause head and hands each one, over a single shared issue bus, to whichever unit is idle at that moment. Operation latency is not known in advance, so units are chosen at run time. The operation stream carries step markers. Operations inside one step may run side by side. Issue stops at the end of a step until every unit that holds work has reported completion.

Each unit reports completion with a pass or fail bit. The dispatcher merges these reports into one clause verdict. On the first failure it stops issuing, lets the operations already in flight finish, and then reports the clause as failed. Units that share an unbound variable coordinate through two shared resources. The first is a bank of write-once binding registers, where the first writer wins and later writers are told the bound value. The second is a table of dereference locks, which are freed when the holder completes. Requests from units to update the heap and trail pointers are serialised by a one-grant-per-cycle arbiter.

Top module: `unify_dispatch`

## Requirements
- R1: At most one operation is issued per cycle. An issue (iss_valid=1) happens exactly when op_valid and op_ready are both 1. The issue goes to the lowest-numbered unit with no outstanding operation, and iss_data carries op_data unchanged. op_ready is 0 while every unit is occupied.
- R2: Once an operation marked op_step_end=1 has been issued, op_ready stays 0 until every issued operation has reported unit_done. Operations inside one step issue in consecutive cycles when units are free.
- R3: A unit_done with unit_fail=1 from a unit that holds an operation stops issue from the next cycle on. Once all in-flight operations have completed, clause_done=1 and clause_fail=1.
- R4: When the operation marked op_last=1 and all earlier operations have completed without failure, clause_done=1 and clause_fail=0. clause_done rises only when no operation is outstanding and holds until the next accepted clause_start.
- R5: A unit_done pulse, with or without unit_fail, from a unit that holds no operation affects neither issue nor the clause verdict.
- R6: Unit u writes binding register k by setting wo_req[u] with wo_addr[u*3 +: 3]=k and wo_wdata[u*16 +: 16]. On the first write since the clause started, the register binds with wo_first=1 and wo_rdata=the written value. Later writes leave it unchanged and return the bound value with wo_first=0.
- R7: When several units request a binding register in the same cycle, only the lowest-numbered one is served (wo_gnt one-hot). The others see wo_gnt=0 and must retry.
- R8: clause_start is accepted only when idle or after clause_done. It unbinds all binding registers and clears the failure state. A clause_start while a clause is running is ignored.
- R9: Unit u requests lock j with lk_req[u] and lk_addr[u*3 +: 3]=j. The lock is granted if it is free or already held by u. A lock held by another unit is not granted until a unit_done from its holder, and it is grantable in that same cycle. Same-cycle requests for one free lock go to the lowest-numbered unit.
- R10: ptr_gnt holds at most one bit and grants the lowest-numbered unit that has ptr_req set.
- R11: During and right after reset, before any clause_start, op_ready, iss_valid and clause_done are 0. With no requests pending, wo_gnt, lk_gnt and ptr_gnt are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clause_start | input | 1 | Begin a new clause head |
| op_valid | input | 1 | Operation offered |
| op_data | input | 16 | Operation payload |
| op_step_end | input | 1 | Offered operation closes its parallel step |
| op_last | input | 1 | Offered operation is the last of the clause |
| op_ready | output | 1 | Dispatcher accepts the offered operation |
| iss_valid | output | 1 | Issue bus carries an operation |
| iss_unit | output | 2 | Target unit of the issue |
| iss_data | output | 16 | Issued payload |
| unit_done | input | 4 | Per-unit completion pulse |
| unit_fail | input | 4 | Per-unit failure flag qualifying unit_done |
| clause_done | output | 1 | Clause verdict available |
| clause_fail | output | 1 | Clause unification failed |
| wo_req | input | 4 | Binding register write request per unit |
| wo_addr | input | 12 | Register index per unit, 3 bits each |
| wo_wdata | input | 64 | Value to bind per unit, 16 bits each |
| wo_gnt | output | 4 | Binding request served this cycle |
| wo_rdata | output | 16 | Value now held by the addressed register |
| wo_first | output | 1 | The served write performed the binding |
| lk_req | input | 4 | Lock request per unit |
| lk_addr | input | 12 | Lock index per unit, 3 bits each |
| lk_gnt | output | 4 | Lock granted this cycle |
| ptr_req | input | 4 | Heap/trail pointer update request per unit |
| ptr_gnt | output | 4 | Pointer update grant |

## Verification
The bench targets a step closing while units are still busy. A design that ignored the barrier would issue the next step early and break the issue-gating check. It also runs steps wider than the unit pool, where a dispatcher that did not track occupancy would issue to a unit that is still working. It sends failures that arrive while other work is in flight, and stray completion pulses from idle units. A design without fail-fast would keep issuing, and one that counted stray pulses would flip the verdict or free a busy unit. Directed sequences check second writes to a bound register, same-cycle contention for a register and for a lock, and a lock handed over in the cycle its holder completes. A wrong implementation would show up here as a wrong bound value, two grants in one cycle, or a one-cycle handover bubble.

// File: rtl/udisp_pkg.sv
package udisp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2,
    ST_DONE  = 2'd3
  } disp_state_e;
endpackage

// File: rtl/udisp_issue.sv
module udisp_issue
  import udisp_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int OP_W      = 16,
  localparam int UNIT_W   = $clog2(NUM_UNITS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clause_start,
  input  logic                 op_valid,
  input  logic [OP_W-1:0]      op_data,
  input  logic                 op_step_end,
  input  logic                 op_last,
  output logic                 op_ready,
  output logic                 iss_valid,
  output logic [UNIT_W-1:0]    iss_unit,
  output logic [OP_W-1:0]      iss_data,
  input  logic [NUM_UNITS-1:0] unit_done,
  input  logic [NUM_UNITS-1:0] unit_fail,
  output logic                 clause_done,
  output logic                 clause_fail,
  output logic                 clear
);

  disp_state_e          state_q, state_n;
  logic [NUM_UNITS-1:0] busy_q, busy_n;
  logic                 fail_q, fail_n;
  logic                 wait_q, wait_n;
  logic                 any_free;
  logic [UNIT_W-1:0]    pick;
  logic                 running;
  logic                 fail_hit;
  logic [NUM_UNITS-1:0] issue_vec;

  // lowest-numbered idle unit
  always_comb begin
    any_free = 1'b0;
    pick     = '0;
    for (int i = NUM_UNITS - 1; i >= 0; i--) begin
      if (!busy_q[i]) begin
        any_free = 1'b1;
        pick     = UNIT_W'(i);
      end
    end
  end

  assign running   = (state_q == ST_RUN) || (state_q == ST_DRAIN);
  assign fail_hit  = running && (|(unit_done & unit_fail & busy_q));
  assign clear     = clause_start && ((state_q == ST_IDLE) || (state_q == ST_DONE));
  assign op_ready  = (state_q == ST_RUN) && !fail_q && any_free &&
                     (!wait_q || (busy_q == '0));
  assign iss_valid = op_valid && op_ready;
  assign iss_unit  = pick;
  assign iss_data  = op_data;

  always_comb begin
    issue_vec = '0;
    if (iss_valid) issue_vec[pick] = 1'b1;
  end

  always_comb begin
    state_n = state_q;
    busy_n  = (busy_q & ~unit_done) | issue_vec;
    fail_n  = fail_q | fail_hit;
    wait_n  = iss_valid ? (op_step_end || op_last) : (wait_q && (busy_q != '0));
    case (state_q)
      ST_IDLE:  if (clause_start) state_n = ST_RUN;
      ST_RUN: begin
        if (iss_valid && op_last)            state_n = ST_DRAIN;
        else if (fail_q && (busy_q == '0))   state_n = ST_DONE;
      end
      ST_DRAIN: if (busy_q == '0) state_n = ST_DONE;
      ST_DONE:  if (clause_start) state_n = ST_RUN;
      default:  state_n = ST_IDLE;
    endcase
    if (clear) begin
      busy_n = '0;
      fail_n = 1'b0;
      wait_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      busy_q  <= '0;
      fail_q  <= 1'b0;
      wait_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      busy_q  <= busy_n;
      fail_q  <= fail_n;
      wait_q  <= wait_n;
    end
  end

  assign clause_done = (state_q == ST_DONE);
  assign clause_fail = (state_q == ST_DONE) && fail_q;

  AST_ISSUE_IDLE_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> !busy_q[iss_unit]); // R1
  AST_STEP_BARRIER: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && (op_step_end || op_last)) |=> !iss_valid); // R2
  AST_FAIL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    fail_hit |=> !iss_valid); // R3
  AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    clause_done |-> (busy_q == '0)); // R4

endmodule

// File: rtl/udisp_wonce.sv
module udisp_wonce #(
  parameter int NUM_UNITS = 4,
  parameter int NUM_REGS  = 8,
  parameter int DATA_W    = 16,
  localparam int UNIT_W   = $clog2(NUM_UNITS),
  localparam int ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clear,
  input  logic [NUM_UNITS-1:0]          wo_req,
  input  logic [NUM_UNITS*ADDR_W-1:0]   wo_addr,
  input  logic [NUM_UNITS*DATA_W-1:0]   wo_wdata,
  output logic [NUM_UNITS-1:0]          wo_gnt,
  output logic [DATA_W-1:0]             wo_rdata,
  output logic                          wo_first
);

  logic [NUM_REGS-1:0] bound_q, bound_n;
  logic [DATA_W-1:0]   val_q [NUM_REGS];
  logic [DATA_W-1:0]   val_n [NUM_REGS];
  logic [ADDR_W-1:0]   addr_u [NUM_UNITS];
  logic [DATA_W-1:0]   data_u [NUM_UNITS];
  logic                hit;
  logic [UNIT_W-1:0]   sel;
  logic [ADDR_W-1:0]   addr_s;
  logic [DATA_W-1:0]   data_s;

  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unpack
    assign addr_u[g] = wo_addr[g*ADDR_W +: ADDR_W];
    assign data_u[g] = wo_wdata[g*DATA_W +: DATA_W];
  end

  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int i = NUM_UNITS - 1; i >= 0; i--) begin
      if (wo_req[i]) begin
        hit = 1'b1;
        sel = UNIT_W'(i);
      end
    end
    for (int i = 0; i < NUM_UNITS; i++) wo_gnt[i] = hit && (sel == UNIT_W'(i));
  end

  assign addr_s   = addr_u[sel];
  assign data_s   = data_u[sel];
  assign wo_first = hit && !bound_q[addr_s];
  assign wo_rdata = !hit ? '0 : (bound_q[addr_s] ? val_q[addr_s] : data_s);

  always_comb begin
    for (int r = 0; r < NUM_REGS; r++) begin
      bound_n[r] = bound_q[r];
      val_n[r]   = val_q[r];
      if (wo_first && (addr_s == ADDR_W'(r))) begin
        bound_n[r] = 1'b1;
        val_n[r]   = data_s;
      end
    end
    if (clear) bound_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bound_q <= '0;
      for (int r = 0; r < NUM_REGS; r++) val_q[r] <= '0;
    end else begin
      bound_q <= bound_n;
      for (int r = 0; r < NUM_REGS; r++) val_q[r] <= val_n[r];
    end
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_chk
    AST_WO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (bound_q[r] && !clear) |=> (bound_q[r] && $stable(val_q[r]))); // R6
  end
  AST_WO_GNT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (wo_gnt & ~wo_req) == '0); // R7

endmodule

// File: rtl/udisp_locks.sv
module udisp_locks #(
  parameter int NUM_UNITS = 4,
  parameter int NUM_LOCKS = 8,
  localparam int UNIT_W   = $clog2(NUM_UNITS),
  localparam int LOCK_W   = $clog2(NUM_LOCKS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear,
  input  logic [NUM_UNITS-1:0]        lk_req,
  input  logic [NUM_UNITS*LOCK_W-1:0] lk_addr,
  input  logic [NUM_UNITS-1:0]        rel,
  output logic [NUM_UNITS-1:0]        lk_gnt
);

  logic [NUM_LOCKS-1:0] held_q, held_n;
  logic [UNIT_W-1:0]    owner_q [NUM_LOCKS];
  logic [UNIT_W-1:0]    owner_n [NUM_LOCKS];
  logic [LOCK_W-1:0]    addr_u  [NUM_UNITS];

  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unpack
    assign addr_u[g] = lk_addr[g*LOCK_W +: LOCK_W];
  end

  always_comb begin
    logic own, taken, blk;
    for (int u = 0; u < NUM_UNITS; u++) begin
      own   = held_q[addr_u[u]] && (owner_q[addr_u[u]] == UNIT_W'(u));
      taken = held_q[addr_u[u]] && !rel[owner_q[addr_u[u]]];
      blk   = 1'b0;
      for (int v = 0; v < u; v++) begin
        if (lk_req[v] && (addr_u[v] == addr_u[u])) blk = 1'b1;
      end
      lk_gnt[u] = lk_req[u] && (own || (!taken && !blk));
    end
  end

  always_comb begin
    held_n = held_q;
    for (int l = 0; l < NUM_LOCKS; l++) begin
      owner_n[l] = owner_q[l];
      if (held_q[l] && rel[owner_q[l]]) held_n[l] = 1'b0;
    end
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (lk_gnt[u]) begin
        held_n[addr_u[u]]  = 1'b1;
        owner_n[addr_u[u]] = UNIT_W'(u);
      end
    end
    if (clear) held_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
      for (int l = 0; l < NUM_LOCKS; l++) owner_q[l] <= '0;
    end else begin
      held_q <= held_n;
      for (int l = 0; l < NUM_LOCKS; l++) owner_q[l] <= owner_n[l];
    end
  end

  for (genvar l = 0; l < NUM_LOCKS; l++) begin : g_chk
    AST_LOCK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (held_q[l] && !rel[owner_q[l]] && !clear) |=> (held_q[l] && $stable(owner_q[l]))); // R9
  end

endmodule

// File: rtl/unify_dispatch.sv
module unify_dispatch #(
  parameter int NUM_UNITS = 4,
  parameter int OP_W      = 16,
  parameter int DATA_W    = 16,
  parameter int NUM_REGS  = 8,
  parameter int NUM_LOCKS = 8,
  localparam int UNIT_W   = $clog2(NUM_UNITS),
  localparam int REG_AW   = $clog2(NUM_REGS),
  localparam int LOCK_AW  = $clog2(NUM_LOCKS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clause_start,
  input  logic                         op_valid,
  input  logic [OP_W-1:0]              op_data,
  input  logic                         op_step_end,
  input  logic                         op_last,
  output logic                         op_ready,
  output logic                         iss_valid,
  output logic [UNIT_W-1:0]            iss_unit,
  output logic [OP_W-1:0]              iss_data,
  input  logic [NUM_UNITS-1:0]         unit_done,
  input  logic [NUM_UNITS-1:0]         unit_fail,
  output logic                         clause_done,
  output logic                         clause_fail,
  input  logic [NUM_UNITS-1:0]         wo_req,
  input  logic [NUM_UNITS*REG_AW-1:0]  wo_addr,
  input  logic [NUM_UNITS*DATA_W-1:0]  wo_wdata,
  output logic [NUM_UNITS-1:0]         wo_gnt,
  output logic [DATA_W-1:0]            wo_rdata,
  output logic                         wo_first,
  input  logic [NUM_UNITS-1:0]         lk_req,
  input  logic [NUM_UNITS*LOCK_AW-1:0] lk_addr,
  output logic [NUM_UNITS-1:0]         lk_gnt,
  input  logic [NUM_UNITS-1:0]         ptr_req,
  output logic [NUM_UNITS-1:0]         ptr_gnt
);

  logic clear;

  udisp_issue #(.NUM_UNITS(NUM_UNITS), .OP_W(OP_W)) u_issue (
    .clk, .rst_n, .clause_start, .op_valid, .op_data, .op_step_end, .op_last,
    .op_ready, .iss_valid, .iss_unit, .iss_data, .unit_done, .unit_fail,
    .clause_done, .clause_fail, .clear
  );

  udisp_wonce #(.NUM_UNITS(NUM_UNITS), .NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_wonce (
    .clk, .rst_n, .clear, .wo_req, .wo_addr, .wo_wdata, .wo_gnt, .wo_rdata, .wo_first
  );

  udisp_locks #(.NUM_UNITS(NUM_UNITS), .NUM_LOCKS(NUM_LOCKS)) u_locks (
    .clk, .rst_n, .clear, .lk_req, .lk_addr, .rel(unit_done), .lk_gnt
  );

  // heap/trail pointer updates: one grant per cycle, lowest unit first
  always_comb begin
    ptr_gnt = '0;
    for (int i = NUM_UNITS - 1; i >= 0; i--) begin
      if (ptr_req[i]) begin
        ptr_gnt    = '0;
        ptr_gnt[i] = 1'b1;
      end
    end
  end

  AST_PTR_SERIAL: assert property (@(posedge clk) disable iff (!rst_n)
    (|ptr_req) |-> ($onehot(ptr_gnt) && ((ptr_gnt & ~ptr_req) == '0))); // R10
  AST_ONE_ISSUE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> !iss_valid); // R1

endmodule

// File: tb/test_unify_dispatch.sv
`timescale 1ns/1ps
module test_unify_dispatch;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        clause_start, op_valid, op_step_end, op_last;
  logic [15:0] op_data;
  logic        op_ready, iss_valid;
  logic [1:0]  iss_unit;
  logic [15:0] iss_data;
  logic [3:0]  unit_done, unit_fail;
  logic        clause_done, clause_fail;
  logic [3:0]  wo_req, wo_gnt;
  logic [11:0] wo_addr;
  logic [63:0] wo_wdata;
  logic [15:0] wo_rdata;
  logic        wo_first;
  logic [3:0]  lk_req, lk_gnt;
  logic [11:0] lk_addr;
  logic [3:0]  ptr_req, ptr_gnt;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  unify_dispatch i_unify_dispatch (
    .clk, .rst_n, .clause_start, .op_valid, .op_data, .op_step_end, .op_last,
    .op_ready, .iss_valid, .iss_unit, .iss_data, .unit_done, .unit_fail,
    .clause_done, .clause_fail, .wo_req, .wo_addr, .wo_wdata, .wo_gnt,
    .wo_rdata, .wo_first, .lk_req, .lk_addr, .lk_gnt, .ptr_req, .ptr_gnt
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int lowest_set(input logic [3:0] v);
    for (int i = 0; i < 4; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic idle_inputs();
    clause_start = 0; op_valid = 0; op_step_end = 0; op_last = 0; op_data = '0;
    unit_done = '0; unit_fail = '0; wo_req = '0; wo_addr = '0; wo_wdata = '0;
    lk_req = '0; lk_addr = '0; ptr_req = '0;
  endtask

  task automatic pulse_start();
    @(negedge clk); clause_start = 1;
    @(negedge clk); clause_start = 0;
  endtask

  task automatic wo_write(input int u, input int r, input logic [15:0] d);
    wo_req[u] = 1; wo_addr[u*3 +: 3] = 3'(r); wo_wdata[u*16 +: 16] = d;
  endtask

  // one clause of random operations against a bench model of the units
  task automatic run_clause(input int n, input bit force_pass);
    logic        se[8], fl[8];
    int          lat[8];
    logic [15:0] dat[8];
    logic [3:0]  mbusy, nb, done_v, fail_v;
    logic        mwait, mfail, mdrain, mdone, exp_fail, exp_ready;
    int          cnt[4];
    logic        ufail[4];
    int          idx, exp_u, guard;
    exp_fail = 0;
    for (int i = 0; i < n; i++) begin
      se[i]  = ($urandom % 3) == 0;
      fl[i]  = force_pass ? 1'b0 : (($urandom % 8) == 0);
      lat[i] = 1 + ($urandom % 4);
      dat[i] = 16'($urandom);
      exp_fail |= fl[i];
    end
    se[n-1] = 1;
    pulse_start();
    mbusy = '0; mwait = 0; mfail = 0; mdrain = 0; mdone = 0; idx = 0; guard = 0;
    for (int u = 0; u < 4; u++) begin cnt[u] = 0; ufail[u] = 0; end
    while (guard < 2000) begin
      guard++;
      @(negedge clk);
      done_v = '0; fail_v = '0;
      for (int u = 0; u < 4; u++) begin
        if (mbusy[u]) begin
          if (cnt[u] == 1) begin done_v[u] = 1; fail_v[u] = ufail[u]; end
          else cnt[u]--;
        end else if (($urandom % 16) == 0) begin
          done_v[u] = 1; fail_v[u] = 1;          // stray report, R5
        end
      end
      unit_done = done_v; unit_fail = fail_v;
      op_valid = (idx < n) && !mdone;
      if (idx < n) begin
        op_data = dat[idx]; op_step_end = se[idx]; op_last = (idx == n - 1);
      end
      #1;
      exp_ready = !mfail && !mdrain && !mdone && (mbusy != 4'hF) &&
                  !(mwait && (mbusy != 0)) && (idx < n);
      chk("R2 issue gating", int'(iss_valid), int'(exp_ready));
      exp_u = lowest_set(~mbusy);
      if (iss_valid) begin
        chk("R1 lowest idle unit", int'(iss_unit), exp_u);
        chk("R1 payload", int'(iss_data), int'(dat[idx]));
      end
      chk("R4 clause_done", int'(clause_done), int'(mdone));
      if (mdone) begin
        chk("R3 clause verdict", int'(clause_fail), int'(exp_fail));
        break;
      end
      nb = mbusy & ~done_v;
      if (iss_valid && exp_ready && exp_u >= 0) begin
        nb[exp_u] = 1; cnt[exp_u] = lat[idx]; ufail[exp_u] = fl[idx];
        mdrain = mdrain || (idx == n - 1);
        mdone  = mdone || (mfail && mbusy == 0);
        mwait  = se[idx];
        idx++;
      end else begin
        mdone = mdone || ((mdrain || mfail) && mbusy == 0);
        mwait = mwait && (mbusy != 0);
      end
      mfail = mfail || (|(done_v & fail_v & mbusy));
      mbusy = nb;
    end
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #(4ns * 150000);
    n_fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    idle_inputs();
    rst_n = 0;
    op_valid = 1;
    repeat (3) @(negedge clk);
    #1;
    chk("R11 op_ready in reset", int'(op_ready), 0);
    chk("R11 iss_valid in reset", int'(iss_valid), 0);
    chk("R11 clause_done in reset", int'(clause_done), 0);
    chk("R11 grants idle", int'({wo_gnt, lk_gnt, ptr_gnt}), 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk); #1;
    chk("R11 idle before start", int'(op_ready), 0);
    op_valid = 0;

    pulse_start();                       // enter running state, no ops offered

    // write-once registers, R6 / R7
    @(negedge clk); wo_write(2, 3, 16'hA1A1); #1;
    chk("R6 first write gnt", int'(wo_gnt), 4'b0100);
    chk("R6 first write data", int'(wo_rdata), 16'hA1A1);
    chk("R6 first write flag", int'(wo_first), 1);
    @(negedge clk); wo_req = '0; wo_write(0, 3, 16'hB2B2); #1;
    chk("R6 second write data", int'(wo_rdata), 16'hA1A1);
    chk("R6 second write flag", int'(wo_first), 0);
    @(negedge clk); wo_req = '0; wo_write(1, 5, 16'h1111); wo_write(3, 5, 16'h3333); #1;
    chk("R7 contention gnt", int'(wo_gnt), 4'b0010);
    chk("R7 contention data", int'(wo_rdata), 16'h1111);
    @(negedge clk); wo_req = '0; wo_write(3, 5, 16'h3333); #1;
    chk("R7 retry gets bound value", int'(wo_rdata), 16'h1111);
    chk("R7 retry flag", int'(wo_first), 0);
    @(negedge clk); wo_req = '0; clause_start = 1;   // ignored while running
    @(negedge clk); clause_start = 0; wo_write(1, 3, 16'hC3C3); #1;
    chk("R8 start ignored while running", int'(wo_rdata), 16'hA1A1);
    @(negedge clk); wo_req = '0;

    // dereference locks, R9
    lk_req[1] = 1; lk_addr[3 +: 3] = 3'd2; #1;
    chk("R9 free lock granted", int'(lk_gnt), 4'b0010);
    @(negedge clk); lk_req = '0;
    lk_req[0] = 1; lk_addr[0 +: 3] = 3'd2; lk_req[3] = 1; lk_addr[9 +: 3] = 3'd5; #1;
    chk("R9 held lock stalls", int'(lk_gnt), 4'b1000);
    @(negedge clk); lk_req[3] = 0; unit_done[1] = 1; #1;
    chk("R9 release same cycle", int'(lk_gnt), 4'b0001);
    @(negedge clk); unit_done = '0;
    lk_req[1] = 1; lk_addr[3 +: 3] = 3'd2; lk_req[2] = 1; lk_addr[6 +: 3] = 3'd2; #1;
    chk("R9 holder keeps lock", int'(lk_gnt), 4'b0001);
    @(negedge clk); lk_req = '0; unit_done = 4'b1001;
    @(negedge clk); unit_done = '0;
    lk_req[1] = 1; lk_addr[3 +: 3] = 3'd7; lk_req[2] = 1; lk_addr[6 +: 3] = 3'd7; #1;
    chk("R9 same-cycle contention", int'(lk_gnt), 4'b0010);
    @(negedge clk); lk_req = '0; unit_done = 4'b0010;

    // pointer serialisation, R10
    @(negedge clk); unit_done = '0; ptr_req = 4'b1010; #1;
    chk("R10 lowest requester", int'(ptr_gnt), 4'b0010);
    @(negedge clk); ptr_req = 4'b1100; #1;
    chk("R10 single grant", int'(ptr_gnt), 4'b0100);
    @(negedge clk); ptr_req = '0;

    // stray completion with failure from idle units, R5
    @(negedge clk); unit_done = 4'hF; unit_fail = 4'hF;
    @(negedge clk); idle_inputs();

    run_clause(6, 1'b1);                 // R5: no failing op, verdict must pass

    pulse_start();                       // accepted after done: clears bindings
    @(negedge clk); wo_write(0, 3, 16'hC3C3); #1;
    chk("R8 cleared binding", int'(wo_first), 1);
    chk("R8 cleared binding data", int'(wo_rdata), 16'hC3C3);
    @(negedge clk); wo_req = '0;

    for (int k = 0; k < 30; k++) run_clause(1 + int'($urandom % 8), 1'b0);
    run_clause(8, 1'b1);

    finish_run();
  end

endmodule